// File: doc/BRIEF.md
# Eight-Bit Up/Down Timer with Buffered Compare

This block is an 8-bit timer/counter that advances on a selectable timer tick and compares its count against a compare value on every tick. The tick comes from one of three sources: the system clock itself, an externally supplied prescaler tick, or an edge of an external pin. The pin is synchronised and then edge-detected. A 2-bit mode input picks one of three count sequences. In free-running mode the count wraps from 0xFF to 0x00. In clear-on-match mode the top of the sequence is the compare value. In phase-correct mode the count climbs to 0xFF and then falls back to 0x00.

Software writes a compare buffer, writes the counter, and clears two sticky flags (overflow and compare match) through a small write port. The buffer reaches the active compare register at a fixed point in the sequence, so that the top and the match threshold never change partway through a period. A waveform output toggles or is forced on each match, which gives a square wave of programmable frequency or a PWM signal.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset the count, the active compare value, both flags and the waveform output are all 0, and the direction is up.
- R2: Tick source by clk_sel: 000 gives no ticks and the count holds. 001 ticks every clock. 010 to 101 tick when pre_tick is high. 110 ticks on a falling edge of ext_pin and 111 on a rising edge. The pin passes through a two-stage synchroniser and then an edge detector, so the count moves on the third clock edge after the pin changes.
- R3: Mode 00 (and the reserved mode 11): each tick adds one to the count, and 0xFF wraps to 0x00. The tick that wraps sets the overflow flag.
- R4: Mode 01: a tick while the count equals the active compare value loads 0x00. Any other tick adds one, so the period is compare+1 ticks.
- R5: Mode 10: the count rises to 0xFF, falls to 0x00, then rises again. The tick that leaves 0x00 while counting down sets the overflow flag.
- R6: A write to address 1 fills the compare buffer. In modes 00 and 11 the active value takes the written value at once. In mode 01 the buffer moves to the active value on the tick at the top of the sequence. In mode 10 it moves on the tick at 0xFF while counting up. At any other time the active value holds.
- R7: A tick taken while the count equals the active compare value is a match, and a match sets the compare flag (bit 1).
- R8: A write to the counter (address 0) replaces the count. The next tick only advances the count and cannot produce a match. Later ticks match normally.
- R9: Writing address 2 clears flag bit 0 (overflow) and flag bit 1 (compare) wherever the data bit is 1. Bits written as 0 leave their flag unchanged.
- R10: On a match the waveform output toggles in modes 00, 01 and 11. In mode 10 it goes to 0 on a match while counting up and to 1 on a match while counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source select |
| ext_pin | input | 1 | External clock pin, asynchronous |
| pre_tick | input | 1 | Prescaled tick, one clock wide |
| mode | input | 2 | Count sequence select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 counter, 1 compare buffer, 2 flag clear |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current count |
| cmp_val | output | 8 | Active compare value |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_cmp | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Waveform output |

## Verification
The assertions assume that mode changes only while no ticks are arriving, and that pre_tick and ext_pin are quiet enough that an idle tick source truly means a frozen count. The stimulus follows these rules: it sets clk_sel to 000 before any change of mode, counter value or compare value, and it holds the pin steady for several clocks between transitions. Inside that envelope the bench sweeps whole periods of every mode and works out each expected count, wave level and flag from the tick number.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam logic [1:0] MODE_FREE  = 2'b00;
    localparam logic [1:0] MODE_CLEAR = 2'b01;
    localparam logic [1:0] MODE_PHASE = 2'b10;

    localparam logic [1:0] ADDR_CNT   = 2'd0;
    localparam logic [1:0] ADDR_CMP   = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;

    localparam int FLAG_OVF_BIT = 0;
    localparam int FLAG_CMP_BIT = 1;
endpackage

// File: rtl/tmr8_clksel.sv
module tmr8_clksel #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       ext_pin,
    input  logic       pre_tick,
    output logic       tick
);
    typedef struct packed {
        logic [SYNC:0] sh;
    } st_t;

    st_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[SYNC-1:0], ext_pin};
        rise   = s_q.sh[SYNC-1] & ~s_q.sh[SYNC];
        fall   = ~s_q.sh[SYNC-1] & s_q.sh[SYNC];
        case (clk_sel)
            3'b000:  tick = 1'b0;
            3'b001:  tick = 1'b1;
            3'b110:  tick = fall;
            3'b111:  tick = rise;
            default: tick = pre_tick;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: no tick ever leaves while the source is off
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b000) |-> !tick);
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cmp_act,
    output logic [W-1:0] count,
    output logic         dir_up,
    output logic         blocked,
    output logic         ovf_evt,
    output logic         load_evt
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] BOTV = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
        logic         blk;
    } st_t;

    st_t s_d, s_q;
    logic [W-1:0] top_val;
    logic at_top, at_bot, adv;

    always_comb begin
        s_d      = s_q;
        top_val  = (mode == MODE_CLEAR) ? cmp_act : MAXV;
        at_top   = (s_q.cnt == top_val);
        at_bot   = (s_q.cnt == BOTV);
        adv      = tick & ~cnt_wr;
        ovf_evt  = 1'b0;
        load_evt = 1'b0;
        if (mode != MODE_PHASE) s_d.dir = 1'b1;
        if (cnt_wr) begin
            s_d.cnt = wr_val;
            s_d.blk = 1'b1;
        end else if (tick) begin
            s_d.blk = 1'b0;
            case (mode)
                MODE_PHASE: begin
                    if (s_q.dir) begin
                        if (at_top) begin
                            s_d.dir  = 1'b0;
                            s_d.cnt  = s_q.cnt - ONE;
                            load_evt = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + ONE;
                        end
                    end else if (at_bot) begin
                        s_d.dir = 1'b1;
                        s_d.cnt = s_q.cnt + ONE;
                        ovf_evt = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE;
                    end
                end
                MODE_CLEAR: begin
                    s_d.cnt  = at_top ? BOTV : s_q.cnt + ONE;
                    load_evt = at_top;
                    ovf_evt  = (s_q.cnt == MAXV);
                end
                default: begin
                    s_d.cnt = s_q.cnt + ONE;
                    ovf_evt = (s_q.cnt == MAXV);
                end
            endcase
        end
        count   = s_q.cnt;
        dir_up  = s_q.dir;
        blocked = s_q.blk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, dir: 1'b1, blk: 1'b0};
        else        s_q <= s_d;
    end

    // R2: without a tick or a write the count is frozen
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));
    // R4: clear-on-match returns to zero after the top
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode == MODE_CLEAR && count == cmp_act) |=> (count == BOTV));
    // R5: phase-correct steps by exactly one either way
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode == MODE_PHASE) |=>
        (count == W'($past(count) + ONE) || count == W'($past(count) - ONE)));
endmodule

// File: rtl/tmr8_compare.sv
module tmr8_compare
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         buf_wr,
    input  logic [W-1:0] wr_val,
    input  logic         load_evt,
    input  logic         match_ok,
    input  logic [W-1:0] count,
    input  logic         dir_up,
    output logic [W-1:0] cmp_act,
    output logic         match_evt,
    output logic         wave
);
    typedef struct packed {
        logic [W-1:0] buf_v;
        logic [W-1:0] act;
        logic         wav;
    } st_t;

    st_t s_d, s_q;
    logic direct;

    always_comb begin
        s_d       = s_q;
        direct    = (mode != MODE_CLEAR) && (mode != MODE_PHASE);
        match_evt = match_ok && (count == s_q.act);
        if (buf_wr) s_d.buf_v = wr_val;
        if (buf_wr && direct)  s_d.act = wr_val;
        else if (load_evt)     s_d.act = s_q.buf_v;
        if (match_evt) begin
            if (mode == MODE_PHASE) s_d.wav = ~dir_up;
            else                    s_d.wav = ~s_q.wav;
        end
        cmp_act = s_q.act;
        wave    = s_q.wav;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: active value only moves on a direct write or a load point
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_wr && !load_evt) |=> $stable(cmp_act));
    // R10: phase-correct up-count match drives the output low
    a_r10_up_low: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mode == MODE_PHASE && dir_up) |=> !wave);
    // R10: phase-correct down-count match drives the output high
    a_r10_dn_high: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mode == MODE_PHASE && !dir_up) |=> wave);
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
    import tmr8_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   clk_sel,
    input  logic         ext_pin,
    input  logic         pre_tick,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp_val,
    output logic         flag_ovf,
    output logic         flag_cmp,
    output logic         wave_out
);
    typedef struct packed {
        logic ovf;
        logic cmp;
    } st_t;

    st_t s_d, s_q;
    logic tick, cnt_wr, buf_wr, flg_wr;
    logic dir_up, blocked, ovf_evt, load_evt, match_ok, match_evt;

    tmr8_clksel #(.SYNC(SYNC)) u_sel (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .ext_pin(ext_pin), .pre_tick(pre_tick), .tick(tick)
    );

    tmr8_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .cnt_wr(cnt_wr), .wr_val(wr_data), .cmp_act(cmp_val),
        .count(count), .dir_up(dir_up), .blocked(blocked),
        .ovf_evt(ovf_evt), .load_evt(load_evt)
    );

    tmr8_compare #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .mode(mode), .buf_wr(buf_wr),
        .wr_val(wr_data), .load_evt(load_evt), .match_ok(match_ok),
        .count(count), .dir_up(dir_up), .cmp_act(cmp_val),
        .match_evt(match_evt), .wave(wave_out)
    );

    always_comb begin
        s_d      = s_q;
        cnt_wr   = wr_en && (wr_addr == ADDR_CNT);
        buf_wr   = wr_en && (wr_addr == ADDR_CMP);
        flg_wr   = wr_en && (wr_addr == ADDR_FLAG);
        match_ok = tick && !cnt_wr && !blocked;
        if (flg_wr && wr_data[FLAG_OVF_BIT]) s_d.ovf = 1'b0;
        if (flg_wr && wr_data[FLAG_CMP_BIT]) s_d.cmp = 1'b0;
        if (ovf_evt)   s_d.ovf = 1'b1;
        if (match_evt) s_d.cmp = 1'b1;
        flag_ovf = s_q.ovf;
        flag_cmp = s_q.cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: the tick right after a counter write never matches
    a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !match_evt);
    // R9: clearing the overflow flag with no new event leaves it low
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_wr && wr_data[FLAG_OVF_BIT] && !ovf_evt) |=> !flag_ovf);
    // R7: a match always leaves the compare flag set
    a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> flag_cmp);
endmodule

// File: tb/sim_tmr8_cmp.sv
module sim_tmr8_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       ext_pin = 1'b0;
    logic       pre_tick = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count, cmp_val;
    logic       flag_ovf, flag_cmp, wave_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tmr8_cmp u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_pin(ext_pin),
        .pre_tick(pre_tick), .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .cmp_val(cmp_val),
        .flag_ovf(flag_ovf), .flag_cmp(flag_cmp), .wave_out(wave_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int w0, ex;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 cmp_val", int'(cmp_val), 0);
        chk("R1 flags", int'({flag_ovf, flag_cmp}), 0);
        chk("R1 wave", int'(wave_out), 0);

        // R2 idle source
        step(20);
        chk("R2 idle count", int'(count), 0);

        // R3 free-running sweep
        clk_sel = 3'd1;
        for (int i = 1; i <= 300; i++) begin
            step(1);
            chk("R3 count", int'(count), i % 256);
            if (i == 255) chk("R3 ovf before wrap", int'(flag_ovf), 0);
            if (i == 256) chk("R3 ovf at wrap", int'(flag_ovf), 1);
        end
        clk_sel = 3'd0;
        step(1);

        // R9 flag clearing
        wr(2, 0);
        chk("R9 zero write keeps ovf", int'(flag_ovf), 1);
        wr(2, 2);
        chk("R9 bit1 only keeps ovf", int'(flag_ovf), 1);
        chk("R9 bit1 clears cmp", int'(flag_cmp), 0);
        wr(2, 1);
        chk("R9 bit0 clears ovf", int'(flag_ovf), 0);

        // R6/R7/R10 free-running compare, immediate update
        wr(1, 20);
        chk("R6 immediate in mode 00", int'(cmp_val), 20);
        wr(0, 10);
        wr(2, 3);
        w0 = int'(wave_out);
        clk_sel = 3'd1;
        step(10);
        chk("R7 no match yet", int'(flag_cmp), 0);
        step(1);
        chk("R7 count past match", int'(count), 21);
        chk("R7 match flag", int'(flag_cmp), 1);
        chk("R10 toggle mode 00", int'(wave_out), 1 - w0);

        // R8 write blocks next match only
        clk_sel = 3'd0;
        wr(0, 20);
        wr(2, 3);
        w0 = int'(wave_out);
        clk_sel = 3'd1;
        step(1);
        chk("R8 count", int'(count), 21);
        chk("R8 blocked flag", int'(flag_cmp), 0);
        chk("R8 blocked wave", int'(wave_out), w0);
        step(255);
        chk("R8 later match flag", int'(flag_cmp), 0);
        step(1);
        chk("R8 later match flag", int'(flag_cmp), 1);

        // R4 clear-on-match
        clk_sel = 3'd0;
        wr(1, 5);
        mode = 2'd1;
        wr(0, 0);
        wr(2, 3);
        w0 = int'(wave_out);
        clk_sel = 3'd1;
        for (int i = 1; i <= 30; i++) begin
            step(1);
            chk("R4 count", int'(count), i % 6);
            chk("R10 toggle mode 01", int'(wave_out), w0 ^ ((i / 6) & 1));
        end
        chk("R4 no overflow", int'(flag_ovf), 0);

        // R6 buffered load in clear-on-match
        clk_sel = 3'd0;
        wr(1, 3);
        chk("R6 held in mode 01", int'(cmp_val), 5);
        clk_sel = 3'd1;
        step(5);
        chk("R6 held until top", int'(cmp_val), 5);
        step(1);
        chk("R6 loaded at top", int'(cmp_val), 3);
        chk("R4 count wrapped", int'(count), 0);
        for (int i = 1; i <= 8; i++) begin
            step(1);
            chk("R4 new period", int'(count), i % 4);
        end

        // R5 phase-correct full period
        clk_sel = 3'd0;
        mode = 2'd0;
        wr(1, 100);
        mode = 2'd2;
        wr(1, 50);
        wr(0, 0);
        wr(2, 3);
        clk_sel = 3'd1;
        for (int i = 1; i <= 515; i++) begin
            step(1);
            if (i <= 255)      ex = i;
            else if (i <= 510) ex = 510 - i;
            else               ex = i - 510;
            chk("R5 count", int'(count), ex);
            if (i == 255) chk("R6 held before TOP", int'(cmp_val), 100);
            if (i == 256) chk("R6 loaded at TOP", int'(cmp_val), 50);
            if (i == 510) chk("R5 ovf before bottom tick", int'(flag_ovf), 0);
            if (i == 511) chk("R5 ovf at bottom", int'(flag_ovf), 1);
            if (i >= 101 && i <= 460) chk("R10 up match low", int'(wave_out), 0);
            if (i >= 461) chk("R10 down match high", int'(wave_out), 1);
        end

        // R2 prescaler tick selections
        clk_sel = 3'd0;
        mode = 2'd0;
        wr(0, 0);
        ex = 0;
        for (int s = 2; s <= 5; s++) begin
            clk_sel = 3'(s);
            for (int i = 0; i < 12; i++) begin
                pre_tick = (i % 3 == 0);
                step(1);
                if (pre_tick) ex++;
                chk("R2 prescaler count", int'(count), ex);
            end
            pre_tick = 1'b0;
        end

        // R2 external pin edges
        clk_sel = 3'd0;
        wr(0, 0);
        clk_sel = 3'd7;
        for (int i = 1; i <= 3; i++) begin
            ext_pin = 1'b1;
            step(2);
            chk("R2 sync latency", int'(count), i - 1);
            step(1);
            chk("R2 rising edge", int'(count), i);
            ext_pin = 1'b0;
            step(5);
            chk("R2 falling ignored", int'(count), i);
        end
        clk_sel = 3'd6;
        for (int i = 1; i <= 3; i++) begin
            ext_pin = 1'b1;
            step(5);
            chk("R2 rising ignored", int'(count), 2 + i);
            ext_pin = 1'b0;
            step(5);
            chk("R2 falling edge", int'(count), 3 + i);
        end

        summary();
    end
endmodule